// File: doc/BRIEF.md
# Staggered Carry-Chain Integer Adder

This block adds two 32-bit integers with an optional carry input, but it does not resolve the whole carry chain in one step. Registers cut the chain at the half-word boundary. The lower half and its carry-out are formed in the first stage. The upper half is formed in the second stage from that registered carry. The condition flags are formed in the third stage. The unit therefore holds parts of three operations at once, and it accepts a new operation every clock.

An operation can be marked as dependent. A dependent operation replaces its first operand with the result of the most recent valid operation. The lower half of that result comes straight from the first-stage register. The upper half is picked up one step later from the second-stage register. A chain of dependent additions therefore runs back to back, with no wait for a full 32-bit result. The carry input lets a caller chain multi-word additions by feeding back the carry flag of an earlier result.

Each clock stands for one half-cycle of a double-pumped execution loop. A valid bit travels with the data through every stage.

Top module: `stag_adder`

## Requirements
- R1: While reset is high and after it is released, out_valid, out_sum, out_zero, out_neg, out_carry and out_ovf are all 0 until the first valid operation reaches the output.
- R2: For a valid non-dependent operation presented at clock edge k, out_sum equals (in_a + in_b + in_cin) mod 2^32 after edge k+2. One new operation can be accepted on every edge.
- R3: out_carry is the carry out of bit 31 of the 33-bit sum of the first operand, in_b and in_cin.
- R4: out_zero is 1 exactly when the 32-bit result is zero. This includes results that wrap to zero with a carry out.
- R5: out_neg equals bit 31 of the result.
- R6: out_ovf is 1 exactly when both operands have the same bit 31 and the result's bit 31 differs from it. The first operand is the effective one, after any substitution by a dependent operation.
- R7: When in_dep is 1, in_a is ignored and the first operand is the result of the immediately preceding valid operation. This holds for back-to-back operations, including when a carry crosses from bit 15 into bit 16.
- R8: A dependent operation separated from the operation it depends on by one or more idle cycles still uses the result of the most recent valid operation.
- R9: out_valid equals in_valid from three edges earlier. When out_valid is 0, out_sum and the flags keep their last valid values.
- R10: A dependent operation issued before any valid operation since reset uses zero as its first operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one edge per half-cycle step |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| in_dep | input | 1 | Use the most recent valid result as the first operand |
| in_cin | input | 1 | Carry input added at bit 0 |
| in_a | input | 32 | First operand, ignored when in_dep is 1 |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Result and flags are valid |
| out_sum | output | 32 | 32-bit result |
| out_zero | output | 1 | Result is zero |
| out_neg | output | 1 | Bit 31 of the result |
| out_carry | output | 1 | Carry out of bit 31 |
| out_ovf | output | 1 | Signed overflow |

## Verification
The risky case has two things happening in the same cycle. The dependent operation's lower half reads the bypassed lower half of the previous result. In that same cycle, the previous operation is still forming its upper half from a registered carry. Operations whose lower halves hold 16'hFFFF make every step carry across the half boundary.

The bench provokes this case in three ways: a directed chain of back-to-back dependent increments, a dependent operation placed after bubbles, and random streams that mix dependence, idle cycles and forced 16'hFFFF lower halves. Each output is judged against a bench model of the full 32-bit sum. The model tracks the last valid result independently of the stage registers.

// File: rtl/stag_pkg.sv
`timescale 1ns/1ps
package stag_pkg;

  // Signed overflow from the top bits of both addends and of the result.
  function automatic logic sgn_ovf(input logic a_top, input logic b_top, input logic s_top);
    return (a_top == b_top) && (s_top != a_top);
  endfunction

  typedef struct packed {
    logic ovf;
    logic carry;
    logic neg;
    logic zero;
  } stag_flags_t;

endpackage

// File: rtl/stag_lo_stage.sv
`timescale 1ns/1ps
module stag_lo_stage #(
  parameter int LO_W = 16,
  parameter int HI_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            in_dep,
  input  logic            in_cin,
  input  logic [LO_W-1:0] a_lo,
  input  logic [LO_W-1:0] b_lo,
  input  logic [HI_W-1:0] a_hi,
  input  logic [HI_W-1:0] b_hi,
  output logic            v_q,
  output logic            dep_q,
  output logic [LO_W-1:0] lo_q,
  output logic            cout_q,
  output logic            lozero_q,
  output logic [HI_W-1:0] ahi_q,
  output logic [HI_W-1:0] bhi_q
);

  logic [LO_W-1:0] a_sel;
  logic [LO_W:0]   lo_full;

  // Local bypass: the previous lower half sits in lo_q.
  assign a_sel   = in_dep ? lo_q : a_lo;
  assign lo_full = {1'b0, a_sel} + {1'b0, b_lo} + {{LO_W{1'b0}}, in_cin};

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q      <= 1'b0;
      dep_q    <= 1'b0;
      lo_q     <= '0;
      cout_q   <= 1'b0;
      lozero_q <= 1'b0;
      ahi_q    <= '0;
      bhi_q    <= '0;
    end else begin
      v_q <= in_valid;
      if (in_valid) begin
        dep_q    <= in_dep;
        lo_q     <= lo_full[LO_W-1:0];
        cout_q   <= lo_full[LO_W];
        lozero_q <= (lo_full[LO_W-1:0] == '0);
        ahi_q    <= a_hi;
        bhi_q    <= b_hi;
      end
    end
  end

  // The bypassed lower half must survive idle cycles.
  assert_lo_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(lo_q));

endmodule

// File: rtl/stag_hi_stage.sv
`timescale 1ns/1ps
module stag_hi_stage #(
  parameter int LO_W = 16,
  parameter int HI_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            v_in,
  input  logic            dep_in,
  input  logic            cin,
  input  logic [HI_W-1:0] a_hi,
  input  logic [HI_W-1:0] b_hi,
  input  logic [LO_W-1:0] lo_in,
  input  logic            lozero_in,
  output logic            v_q,
  output logic [HI_W-1:0] hi_q,
  output logic [LO_W-1:0] lo_q,
  output logic            c_q,
  output logic            ov_q,
  output logic            lozero_q
);

  import stag_pkg::*;

  logic [HI_W-1:0] a_sel;
  logic [HI_W:0]   hi_full;

  // Upper-half bypass: hi_q holds the upper half of the last valid result.
  assign a_sel   = dep_in ? hi_q : a_hi;
  assign hi_full = {1'b0, a_sel} + {1'b0, b_hi} + {{HI_W{1'b0}}, cin};

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q      <= 1'b0;
      hi_q     <= '0;
      lo_q     <= '0;
      c_q      <= 1'b0;
      ov_q     <= 1'b0;
      lozero_q <= 1'b0;
    end else begin
      v_q <= v_in;
      if (v_in) begin
        hi_q     <= hi_full[HI_W-1:0];
        lo_q     <= lo_in;
        c_q      <= hi_full[HI_W];
        ov_q     <= sgn_ovf(a_sel[HI_W-1], b_hi[HI_W-1], hi_full[HI_W-1]);
        lozero_q <= lozero_in;
      end
    end
  end

  assert_hi_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !v_in |=> $stable(hi_q));

endmodule

// File: rtl/stag_flag_stage.sv
`timescale 1ns/1ps
module stag_flag_stage #(
  parameter int LO_W = 16,
  parameter int HI_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v_in,
  input  logic [HI_W-1:0]      hi_in,
  input  logic [LO_W-1:0]      lo_in,
  input  logic                 c_in,
  input  logic                 ov_in,
  input  logic                 lozero_in,
  output logic                 out_valid,
  output logic [LO_W+HI_W-1:0] out_sum,
  output stag_pkg::stag_flags_t out_flags
);

  import stag_pkg::*;

  stag_flags_t flags_d;

  always_comb begin
    flags_d.zero  = lozero_in && (hi_in == '0);
    flags_d.neg   = hi_in[HI_W-1];
    flags_d.carry = c_in;
    flags_d.ovf   = ov_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
      out_flags <= '0;
    end else begin
      out_valid <= v_in;
      if (v_in) begin
        out_sum   <= {hi_in, lo_in};
        out_flags <= flags_d;
      end
    end
  end

  assert_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_flags.zero) |-> (out_sum == '0));

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !v_in |=> ($stable(out_sum) && $stable(out_flags)));

endmodule

// File: rtl/stag_adder.sv
`timescale 1ns/1ps
module stag_adder #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_dep,
  input  logic             in_cin,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_sum,
  output logic             out_zero,
  output logic             out_neg,
  output logic             out_carry,
  output logic             out_ovf
);

  import stag_pkg::*;

  localparam int LO_W = WIDTH / 2;
  localparam int HI_W = WIDTH - LO_W;

  logic            s1_v, s1_dep, s1_c, s1_lozero;
  logic [LO_W-1:0] s1_lo;
  logic [HI_W-1:0] s1_ahi, s1_bhi;
  logic            s2_v, s2_c, s2_ov, s2_lozero;
  logic [HI_W-1:0] s2_hi;
  logic [LO_W-1:0] s2_lo;
  stag_flags_t     flags;

  stag_lo_stage #(.LO_W(LO_W), .HI_W(HI_W)) u_lo (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_dep(in_dep), .in_cin(in_cin),
    .a_lo(in_a[LO_W-1:0]), .b_lo(in_b[LO_W-1:0]),
    .a_hi(in_a[WIDTH-1:LO_W]), .b_hi(in_b[WIDTH-1:LO_W]),
    .v_q(s1_v), .dep_q(s1_dep), .lo_q(s1_lo), .cout_q(s1_c),
    .lozero_q(s1_lozero), .ahi_q(s1_ahi), .bhi_q(s1_bhi)
  );

  stag_hi_stage #(.LO_W(LO_W), .HI_W(HI_W)) u_hi (
    .clk(clk), .rst(rst), .v_in(s1_v), .dep_in(s1_dep), .cin(s1_c),
    .a_hi(s1_ahi), .b_hi(s1_bhi), .lo_in(s1_lo), .lozero_in(s1_lozero),
    .v_q(s2_v), .hi_q(s2_hi), .lo_q(s2_lo), .c_q(s2_c), .ov_q(s2_ov),
    .lozero_q(s2_lozero)
  );

  stag_flag_stage #(.LO_W(LO_W), .HI_W(HI_W)) u_flag (
    .clk(clk), .rst(rst), .v_in(s2_v), .hi_in(s2_hi), .lo_in(s2_lo),
    .c_in(s2_c), .ov_in(s2_ov), .lozero_in(s2_lozero),
    .out_valid(out_valid), .out_sum(out_sum), .out_flags(flags)
  );

  assign out_zero  = flags.zero;
  assign out_neg   = flags.neg;
  assign out_carry = flags.carry;
  assign out_ovf   = flags.ovf;

  // Edges since reset, saturating, so the latency check never looks before reset.
  logic [1:0] warm_cnt;
  always_ff @(posedge clk) begin
    if (rst)                warm_cnt <= '0;
    else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
  end

  assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
    (warm_cnt == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_sum == '0));

endmodule

// File: tb/stag_adder_test.sv
`timescale 1ns/1ps
module stag_adder_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_dep = 1'b0, in_cin = 1'b0;
  logic [31:0] in_a = '0, in_b = '0;
  logic        out_valid, out_zero, out_neg, out_carry, out_ovf;
  logic [31:0] out_sum;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  stag_adder #(.WIDTH(32)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_dep(in_dep), .in_cin(in_cin),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_sum(out_sum),
    .out_zero(out_zero), .out_neg(out_neg), .out_carry(out_carry), .out_ovf(out_ovf)
  );

  // Three-deep expectation pipe, index 2 is due at the current sample.
  logic        p_v[3];
  logic [31:0] p_sum[3];
  logic        p_c[3], p_z[3], p_n[3], p_o[3];
  string       p_tag[3];

  logic [31:0] last_res;   // most recent valid result, for dependent ops
  logic [31:0] held_sum;   // last valid value seen at the output
  bit          any_valid;
  int          gap;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_out();
    chk(out_valid == p_v[2], "R9 valid", {31'b0, out_valid}, {31'b0, p_v[2]});
    if (p_v[2]) begin
      chk(out_sum == p_sum[2], p_tag[2], out_sum, p_sum[2]);
      chk(out_carry == p_c[2], "R3 carry", {31'b0, out_carry}, {31'b0, p_c[2]});
      chk(out_zero == p_z[2], "R4 zero", {31'b0, out_zero}, {31'b0, p_z[2]});
      chk(out_neg == p_n[2], "R5 neg", {31'b0, out_neg}, {31'b0, p_n[2]});
      chk(out_ovf == p_o[2], "R6 ovf", {31'b0, out_ovf}, {31'b0, p_o[2]});
      held_sum = p_sum[2];
    end else begin
      chk(out_sum == held_sum, "R9 hold", out_sum, held_sum);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                      input logic cin, input logic dep);
    logic [31:0] aeff;
    logic [32:0] wide;
    string       tag;
    @(negedge clk);
    check_out();
    for (int i = 2; i > 0; i--) begin
      p_v[i] = p_v[i-1]; p_sum[i] = p_sum[i-1]; p_c[i] = p_c[i-1];
      p_z[i] = p_z[i-1]; p_n[i] = p_n[i-1]; p_o[i] = p_o[i-1]; p_tag[i] = p_tag[i-1];
    end
    in_valid = v; in_a = a; in_b = b; in_cin = cin; in_dep = dep;
    aeff = dep ? last_res : a;
    wide = {1'b0, aeff} + {1'b0, b} + {32'b0, cin};
    if (!dep)            tag = "R2 sum";
    else if (!any_valid) tag = "R10 dep-from-reset";
    else if (gap > 0)    tag = "R8 dep-after-gap";
    else                 tag = "R7 dep-back-to-back";
    p_v[0] = v; p_sum[0] = wide[31:0]; p_c[0] = wide[32];
    p_z[0] = (wide[31:0] == 32'd0); p_n[0] = wide[31];
    p_o[0] = (aeff[31] == b[31]) && (wide[31] != aeff[31]);
    p_tag[0] = tag;
    if (v) begin
      last_res = wide[31:0]; any_valid = 1'b1; gap = 0;
    end else begin
      gap++;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 3; i++) begin
      p_v[i] = 1'b0; p_sum[i] = '0; p_c[i] = 1'b0; p_z[i] = 1'b0;
      p_n[i] = 1'b0; p_o[i] = 1'b0; p_tag[i] = "none";
    end
    last_res = '0; held_sum = '0; any_valid = 1'b0; gap = 0;

    repeat (4) @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1 valid", {31'b0, out_valid}, 32'd0);
    chk(out_sum == 32'd0, "R1 sum", out_sum, 32'd0);
    chk({out_zero, out_neg, out_carry, out_ovf} == 4'b0, "R1 flags",
        {28'b0, out_zero, out_neg, out_carry, out_ovf}, 32'd0);
    rst = 1'b0;

    // R10: dependent op before any valid op uses zero
    step(1, 32'hDEAD_BEEF, 32'd5, 0, 1);
    // R4/R3: wrap to zero with carry
    step(1, 32'hFFFF_FFFF, 32'd1, 0, 0);
    // R6/R5: signed overflow into negative
    step(1, 32'h7FFF_FFFF, 32'd1, 0, 0);
    // R2: carry across half boundary plus carry input
    step(1, 32'h0000_FFFF, 32'd0, 1, 0);
    // R7: back-to-back dependent chain crossing the half boundary each step
    step(1, 32'h0000_FFFF, 32'h0000_0000, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 32'h1234_5678, 32'h0000_FFFF, 1, 1);
    // R8: dependent op after bubbles
    step(0, 32'h0, 32'h0, 0, 0);
    step(0, 32'h0, 32'h0, 0, 0);
    step(1, 32'hAAAA_AAAA, 32'h8000_FFFF, 1, 1);
    // R6: negative overflow
    step(1, 32'h8000_0000, 32'h8000_0000, 0, 0);

    // Random mix of dependence, bubbles and boundary-heavy operands
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom; rb = $urandom;
      if (($urandom % 4) == 0) ra[15:0] = 16'hFFFF;
      if (($urandom % 4) == 0) rb[15:0] = 16'hFFFF;
      if (($urandom % 8) == 0) rb = 32'd0 - ra;
      step(($urandom % 5) != 0, ra, rb, $urandom % 2, ($urandom % 2) == 1);
    end
    for (int i = 0; i < 3; i++) step(0, 32'h0, 32'h0, 0, 0);
    @(negedge clk);
    check_out();

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule